// File: doc/BRIEF.md
# Oversampling Serial Receiver with Status-Tagged Buffer

This block receives asynchronous serial characters on a single line and turns them into bytes for a host. A baud tick at sixteen times the bit rate paces it. It waits for a falling edge and confirms the start bit at mid-bit. It then collects eight data bits, least significant first, and an optional parity bit, and checks the stop bit. The finished character goes into a two-entry buffer. The parity-check result and the stop-bit status travel with the byte inside the buffer, so each character keeps the verdict it was given when it arrived.

The host sees the oldest unread character on the data output. While anything is unread, a ready flag is high. The error flags describe that same head character. A one-cycle read strobe drops the head and exposes the next entry. A character that arrives while the buffer is full is lost and raises a sticky overrun flag. Dropping the enable stops reception at once, throws away a frame in progress and empties the buffer.

Top module: `srx_receiver`

## Requirements
- R1: A frame starts with a high-to-low transition of the line. Then come 8 data bits, least significant bit first, an optional parity bit and one stop bit, each 16 ticks long. Each bit is decided by a majority vote of tick samples 7, 8 and 9 within the bit.
- R2: If the line is high again at sample 8 of the start bit, the event is a glitch. No character is stored and the receiver goes back to waiting for a falling edge.
- R3: The parity bit is present and checked only if parity_enable was 1 when the start bit was detected. With parity_odd = 0 the data bits plus the parity bit must hold an even number of ones; with parity_odd = 1, an odd number. A mismatch sets the stored parity-error bit of that entry. Changing parity_enable or parity_odd later leaves stored entries unchanged.
- R4: A stop bit decided low sets the stored framing-error bit of that entry, and the byte is still stored.
- R5: The buffer holds 2 entries and returns them in arrival order. rx_ready is 1 exactly while at least one entry is unread. rd_data, parity_error and frame_error show the head entry, and both error flags read 0 while the buffer is empty.
- R6: A character completed while the buffer is full and no read is being accepted is discarded and sets overrun. overrun stays set until a read strobe removes an entry.
- R7: While rx_enable is 0 any frame in progress is abandoned, the buffer is emptied and overrun is cleared. Nothing is stored until a new falling edge is seen with the enable high.
- R8: A read strobe while the buffer is empty has no effect.
- R9: If a character completes in the same cycle that a read strobe removes the head of a full buffer, the character is stored and overrun is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_line | input | 1 | Serial input line, idle high |
| tick16 | input | 1 | One-cycle pulse at 16 times the bit rate |
| rx_enable | input | 1 | Receiver enable; low aborts reception and empties the buffer |
| parity_enable | input | 1 | Frame carries a parity bit that is checked |
| parity_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| rd_strobe | input | 1 | One-cycle request to remove the head entry |
| rd_data | output | 8 | Data byte of the head entry, 0 when empty |
| rx_ready | output | 1 | At least one unread entry is held |
| parity_error | output | 1 | Head entry failed its parity check |
| frame_error | output | 1 | Head entry had a low stop bit |
| overrun | output | 1 | Sticky flag: a character was lost to a full buffer |

## Verification
A completing character can meet a host read in the same clock cycle while both entries are occupied. That is when the buffer decides between storing the character and raising overrun. The bench fills the buffer with two characters and sends a third. Across a sweep of 34 trials it moves one read strobe cycle by cycle across the stop bit of the third character. After each trial it drains the buffer. Each outcome must either keep the third byte intact behind the second or drop it cleanly. Across the sweep the outcome must switch from kept to dropped exactly once, and overrun must be clear after every trial.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              perr;
    logic              ferr;
  } rx_entry_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_PAR,
    S_STOP
  } rx_state_e;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_n;

  always_comb begin
    pipe_n = {pipe_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '1;
    else        pipe_q <= pipe_n;
  end

  assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/srx_frame_rx.sv
module srx_frame_rx
  import srx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en,
  input  logic      rx_s,
  input  logic      tick,
  input  logic      par_en,
  input  logic      par_odd,
  output logic      push,
  output rx_entry_t push_entry
);
  localparam int CNT_W  = $clog2(OSR);
  localparam int BIDX_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0]  LAST   = CNT_W'(OSR - 1);
  localparam logic [CNT_W-1:0]  S_PRE  = CNT_W'(OSR / 2 - 1);
  localparam logic [CNT_W-1:0]  S_MID  = CNT_W'(OSR / 2);
  localparam logic [CNT_W-1:0]  S_POST = CNT_W'(OSR / 2 + 1);
  localparam logic [BIDX_W-1:0] B_LAST = BIDX_W'(DATA_W - 1);

  rx_state_e          state_q, state_n;
  logic [CNT_W-1:0]   tcnt_q, tcnt_n, idx;
  logic [BIDX_W-1:0]  bidx_q, bidx_n;
  logic [DATA_W-1:0]  shreg_q, shreg_n;
  logic               pre_q, pre_n;
  logic               mid_q, mid_n;
  logic               pbit_q, pbit_n;
  logic               prev_q, prev_n;
  logic               cpar_q, cpar_n;
  logic               codd_q, codd_n;
  logic               vote;

  assign idx  = tcnt_q + CNT_W'(1);
  assign vote = (pre_q & mid_q) | (pre_q & rx_s) | (mid_q & rx_s);

  always_comb begin
    state_n    = state_q;
    tcnt_n     = tcnt_q;
    bidx_n     = bidx_q;
    shreg_n    = shreg_q;
    pre_n      = pre_q;
    mid_n      = mid_q;
    pbit_n     = pbit_q;
    prev_n     = prev_q;
    cpar_n     = cpar_q;
    codd_n     = codd_q;
    push       = 1'b0;
    push_entry = '0;
    if (!en) begin
      state_n = S_IDLE;
      tcnt_n  = '0;
      prev_n  = 1'b0;
    end else if (tick) begin
      prev_n = rx_s;
      if (state_q == S_IDLE) begin
        if (prev_q && !rx_s) begin
          state_n = S_START;
          tcnt_n  = '0;
          cpar_n  = par_en;
          codd_n  = par_odd;
        end
      end else if (tcnt_q == LAST) begin
        tcnt_n = '0;
        case (state_q)
          S_START: begin
            state_n = S_DATA;
            bidx_n  = '0;
          end
          S_DATA: begin
            if (bidx_q == B_LAST) state_n = cpar_q ? S_PAR : S_STOP;
            else                  bidx_n  = bidx_q + BIDX_W'(1);
          end
          S_PAR:   state_n = S_STOP;
          default: state_n = S_IDLE;
        endcase
      end else begin
        tcnt_n = idx;
        if (idx == S_PRE) pre_n = rx_s;
        if (idx == S_MID) begin
          mid_n = rx_s;
          if (state_q == S_START && rx_s) state_n = S_IDLE;
        end
        if (idx == S_POST) begin
          case (state_q)
            S_DATA: shreg_n = {vote, shreg_q[DATA_W-1:1]};
            S_PAR:  pbit_n  = vote;
            S_STOP: begin
              push            = 1'b1;
              push_entry.data = shreg_q;
              push_entry.perr = cpar_q & (^shreg_q ^ pbit_q ^ codd_q);
              push_entry.ferr = ~vote;
              state_n         = S_IDLE;
            end
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      tcnt_q  <= '0;
      bidx_q  <= '0;
      shreg_q <= '0;
      pre_q   <= 1'b1;
      mid_q   <= 1'b1;
      pbit_q  <= 1'b0;
      prev_q  <= 1'b0;
      cpar_q  <= 1'b0;
      codd_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      tcnt_q  <= tcnt_n;
      bidx_q  <= bidx_n;
      shreg_q <= shreg_n;
      pre_q   <= pre_n;
      mid_q   <= mid_n;
      pbit_q  <= pbit_n;
      prev_q  <= prev_n;
      cpar_q  <= cpar_n;
      codd_q  <= codd_n;
    end
  end

  // R2: a start bit seen high at its mid sample is abandoned
  p_start_glitch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && state_q == S_START && tcnt_q == S_PRE && rx_s) |=> state_q == S_IDLE);

  // R7: nothing completes while reception is disabled
  p_push_needs_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> en);
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo
  import srx_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      flush,
  input  logic      push,
  input  rx_entry_t push_entry,
  input  logic      pop,
  output rx_entry_t head,
  output logic      empty,
  output logic      overrun
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  rx_entry_t         mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_q, wr_n, rd_q, rd_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              ovr_q, ovr_n;
  logic              full, pop_ok, accept;

  assign full   = (cnt_q == FULL_CNT);
  assign empty  = (cnt_q == '0);
  assign pop_ok = pop & ~empty;
  assign accept = push & (~full | pop_ok);

  always_comb begin
    wr_n  = wr_q;
    rd_n  = rd_q;
    cnt_n = cnt_q;
    ovr_n = ovr_q;
    if (flush) begin
      wr_n  = '0;
      rd_n  = '0;
      cnt_n = '0;
      ovr_n = 1'b0;
    end else begin
      if (accept) wr_n = (wr_q == PTR_LAST) ? '0 : wr_q + PTR_W'(1);
      if (pop_ok) rd_n = (rd_q == PTR_LAST) ? '0 : rd_q + PTR_W'(1);
      cnt_n = cnt_q + CNT_W'(accept) - CNT_W'(pop_ok);
      if (pop_ok)               ovr_n = 1'b0;
      else if (push && !accept) ovr_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      wr_q  <= wr_n;
      rd_q  <= rd_n;
      cnt_q <= cnt_n;
      ovr_q <= ovr_n;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (accept && !flush && wr_q == PTR_W'(g)) mem_q[g] <= push_entry;
    end
  end

  assign head    = empty ? '0 : mem_q[rd_q];
  assign overrun = ovr_q;

  // R5: occupancy never exceeds the configured depth
  p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT);

  // R7: disabling empties the buffer on the next cycle
  p_flush_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt_q == '0 && !ovr_q));

  // R8: a read on an empty buffer changes nothing
  p_empty_read_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push && !flush) |=> cnt_q == '0);

  // R6: overrun can only rise from a full buffer
  p_overrun_from_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_q) |-> $past(cnt_q) == FULL_CNT);

  // R9: completion meeting a read on a full buffer is kept
  p_race_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && full && !flush) |=> (cnt_q == FULL_CNT && !ovr_q));
endmodule

// File: rtl/srx_receiver.sv
module srx_receiver
  import srx_pkg::*;
#(
  parameter int DEPTH       = 2,
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_line,
  input  logic              tick16,
  input  logic              rx_enable,
  input  logic              parity_enable,
  input  logic              parity_odd,
  input  logic              rd_strobe,
  output logic [DATA_W-1:0] rd_data,
  output logic              rx_ready,
  output logic              parity_error,
  output logic              frame_error,
  output logic              overrun
);
  logic [1:0] rst_pipe_q;
  logic       rst_core_n;
  logic       rx_s;
  logic       push;
  logic       empty;
  rx_entry_t  push_entry;
  rx_entry_t  head;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .d     (rx_line),
    .q     (rx_s)
  );

  srx_frame_rx #(.OSR(OSR)) u_frame (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .en         (rx_enable),
    .rx_s       (rx_s),
    .tick       (tick16),
    .par_en     (parity_enable),
    .par_odd    (parity_odd),
    .push       (push),
    .push_entry (push_entry)
  );

  srx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .flush      (~rx_enable),
    .push       (push),
    .push_entry (push_entry),
    .pop        (rd_strobe),
    .head       (head),
    .empty      (empty),
    .overrun    (overrun)
  );

  assign rd_data      = head.data;
  assign rx_ready     = ~empty;
  assign parity_error = head.perr;
  assign frame_error  = head.ferr;

  // R5: error flags are quiet while nothing is buffered
  p_flags_empty_r5: assert property (@(posedge clk) disable iff (!rst_core_n)
    !rx_ready |-> (!parity_error && !frame_error));
endmodule

// File: tb/srx_receiver_tb_top.sv
module srx_receiver_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_line = 1'b1;
  logic       tick16 = 1'b0;
  logic       rx_enable = 1'b0;
  logic       parity_enable = 1'b0;
  logic       parity_odd = 1'b0;
  logic       rd_strobe = 1'b0;
  logic [7:0] rd_data;
  logic       rx_ready, parity_error, frame_error, overrun;

  int tests = 0;
  int fails = 0;
  bit done  = 0;
  event stop_ev;

  localparam int BITCLK = 64;

  always #5 clk = ~clk;

  initial begin
    forever begin
      repeat (3) @(negedge clk);
      tick16 = 1'b1;
      @(negedge clk);
      tick16 = 1'b0;
    end
  end

  srx_receiver dut_i (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .tick16(tick16),
    .rx_enable(rx_enable), .parity_enable(parity_enable), .parity_odd(parity_odd),
    .rd_strobe(rd_strobe), .rd_data(rd_data), .rx_ready(rx_ready),
    .parity_error(parity_error), .frame_error(frame_error), .overrun(overrun)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic send_frame(input logic [7:0] d, input bit has_par, input bit pbit, input bit stop);
    rx_line = 1'b0;
    repeat (BITCLK) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx_line = d[i];
      repeat (BITCLK) @(negedge clk);
    end
    if (has_par) begin
      rx_line = pbit;
      repeat (BITCLK) @(negedge clk);
    end
    -> stop_ev;
    rx_line = stop;
    repeat (BITCLK) @(negedge clk);
    rx_line = 1'b1;
    repeat (32) @(negedge clk);
  endtask

  task automatic rd_pulse();
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
    @(negedge clk);
  endtask

  task automatic flush_buf();
    rx_enable = 1'b0;
    repeat (2) @(negedge clk);
    rx_enable = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    bit seen_acc, seen_drop, acc;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // Reset state (R5)
    chk("R5", "reset rx_ready", int'(rx_ready), 0);
    chk("R6", "reset overrun", int'(overrun), 0);
    chk("R5", "reset flags", int'(parity_error | frame_error), 0);

    rx_enable = 1'b1;
    repeat (BITCLK) @(negedge clk);

    // Sweep of bytes and parity modes (R1, R3, R5)
    for (int i = 0; i < 52; i++) begin
      logic [7:0] b;
      int mode;
      bit flip, pb;
      b = 8'(i * 5);
      mode = i % 3;
      flip = (mode != 0) && (i % 4 == 1);
      parity_enable = (mode != 0);
      parity_odd = (mode == 2);
      pb = (^b) ^ (mode == 2) ^ flip;
      send_frame(b, mode != 0, pb, 1'b1);
      chk("R5", "ready after frame", int'(rx_ready), 1);
      chk("R1", "data byte", int'(rd_data), int'(b));
      chk("R3", "parity verdict", int'(parity_error), int'(flip));
      chk("R4", "good stop", int'(frame_error), 0);
      rd_pulse();
      chk("R5", "empty after read", int'(rx_ready), 0);
    end

    // Stored verdict survives later config change (R3)
    parity_enable = 1'b1;
    parity_odd = 1'b0;
    send_frame(8'h07, 1'b1, 1'b0, 1'b1);
    parity_enable = 1'b0;
    parity_odd = 1'b1;
    @(negedge clk);
    chk("R3", "stored perr after disable", int'(parity_error), 1);
    chk("R3", "stored data", int'(rd_data), 7);
    rd_pulse();
    parity_enable = 1'b0;
    parity_odd = 1'b0;

    // Start glitch (R2)
    rx_line = 1'b0;
    repeat (8) @(negedge clk);
    rx_line = 1'b1;
    repeat (3 * BITCLK) @(negedge clk);
    chk("R2", "glitch stored nothing", int'(rx_ready), 0);

    // Empty read ignored (R8)
    rd_pulse();
    chk("R8", "empty read ready", int'(rx_ready), 0);
    send_frame(8'hC3, 1'b0, 1'b0, 1'b1);
    chk("R8", "data after empty read", int'(rd_data), 8'hC3);
    rd_pulse();
    chk("R8", "single entry", int'(rx_ready), 0);

    // Framing error, order, overrun (R4, R5, R6)
    send_frame(8'h81, 1'b0, 1'b0, 1'b0);
    send_frame(8'h42, 1'b0, 1'b0, 1'b1);
    chk("R6", "no overrun at two", int'(overrun), 0);
    send_frame(8'h99, 1'b0, 1'b0, 1'b1);
    chk("R6", "overrun set", int'(overrun), 1);
    chk("R4", "low stop byte kept", int'(rd_data), 8'h81);
    chk("R4", "framing flag", int'(frame_error), 1);
    rd_pulse();
    chk("R6", "overrun cleared by read", int'(overrun), 0);
    chk("R5", "second in order", int'(rd_data), 8'h42);
    chk("R5", "head flag follows", int'(frame_error), 0);
    rd_pulse();
    chk("R6", "dropped char gone", int'(rx_ready), 0);

    // Flush clears entries and overrun (R7)
    send_frame(8'h11, 1'b0, 1'b0, 1'b1);
    send_frame(8'h22, 1'b0, 1'b0, 1'b1);
    send_frame(8'h33, 1'b0, 1'b0, 1'b1);
    chk("R6", "overrun before flush", int'(overrun), 1);
    flush_buf();
    chk("R7", "flush ready", int'(rx_ready), 0);
    chk("R7", "flush overrun", int'(overrun), 0);

    // Abort mid-frame (R7)
    fork
      send_frame(8'h55, 1'b0, 1'b0, 1'b1);
      begin
        repeat (3 * BITCLK) @(negedge clk);
        rx_enable = 1'b0;
      end
    join
    rx_enable = 1'b1;
    repeat (2 * BITCLK) @(negedge clk);
    chk("R7", "aborted frame not stored", int'(rx_ready), 0);

    // Full buffer, completion vs read in the same cycle (R9)
    seen_acc = 0;
    seen_drop = 0;
    for (int off = 25; off < 59; off++) begin
      flush_buf();
      send_frame(8'h3C, 1'b0, 1'b0, 1'b1);
      send_frame(8'hA5, 1'b0, 1'b0, 1'b1);
      fork
        send_frame(8'h5A, 1'b0, 1'b0, 1'b1);
        begin
          @(stop_ev);
          repeat (off) @(negedge clk);
          rd_strobe = 1'b1;
          @(negedge clk);
          rd_strobe = 1'b0;
        end
      join
      chk("R9", "overrun after race", int'(overrun), 0);
      chk("R9", "second entry at head", int'(rd_data), 8'hA5);
      rd_pulse();
      acc = rx_ready;
      if (acc) begin
        chk("R9", "third byte intact", int'(rd_data), 8'h5A);
        rd_pulse();
      end
      chk("R9", "drained", int'(rx_ready), 0);
      if (acc && seen_drop) chk("R9", "monotonic outcome", 1, 0);
      if (acc) seen_acc = 1;
      else     seen_drop = 1;
    end
    chk("R9", "some trial kept", int'(seen_acc), 1);
    chk("R9", "some trial dropped", int'(seen_drop), 1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule